// File: doc/BRIEF.md
# Overwrite-Oldest Circular Byte Buffer

This block is a byte-wide circular buffer that keeps a history of the most recent bytes pushed into it. A write is never refused. Once the buffer is full, each new byte replaces the oldest stored byte, so the contents always reflect the latest `DEPTH` bytes. A reader pops bytes oldest-first. When nothing is stored, the read port returns an all-ones sentinel and leaves the state untouched.

The head byte is shown combinationally on the pop data output. A consumer can therefore sample the byte in the same cycle it raises the pop strobe. A synchronous clear empties the buffer in one cycle. The depth is a power-of-two parameter, which lets both indices wrap by truncation.

Top module: `obuf_ring`

## Requirements
- R1: After reset, `count_o` is 0 and `pop_data_o` shows 0xFF. A cycle with `clear_i` high empties the buffer, so `count_o` is 0 afterwards. A push or pop in the same cycle as the clear has no effect.
- R2: A push into a buffer that is not full, with no pop, raises `count_o` by one. The byte goes in behind all stored bytes. When the buffer was empty, `pop_data_o` shows the pushed byte on the next cycle.
- R3: A push into a full buffer is accepted and `count_o` stays at `DEPTH`. The oldest byte is discarded, so later pops return the latest `DEPTH` pushed bytes in push order.
- R4: While `count_o` is nonzero, `pop_data_o` shows the oldest stored byte combinationally. This holds in the same cycle as `pop_i`. A pop alone lowers `count_o` by one and exposes the next-oldest byte.
- R5: While `count_o` is 0, `pop_data_o` is 0xFF. A pop with no push then leaves `count_o` at 0 and changes no stored state.
- R6: A push and a pop in the same cycle act as pop first, then push. On a nonempty buffer (including a full one), `count_o` is unchanged and the byte order is preserved. On an empty buffer, the pop returns 0xFF and `count_o` becomes 1.
- R7: `count_o` never exceeds `DEPTH`. Under long mixed traffic, both indices wrap modulo `DEPTH` with no loss or reordering beyond the overwrite rule of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of indices and count |
| push_valid_i | input | 1 | Push strobe, always accepted |
| push_data_i | input | DATA_W | Byte to push |
| pop_i | input | 1 | Pop strobe |
| pop_data_o | output | DATA_W | Oldest stored byte, or all-ones when empty |
| count_o | output | $clog2(DEPTH)+1 | Number of stored bytes |

## Verification
The buffer is driven in several patterns:
- Isolated pushes and pops, which separate the plain append and remove paths.
- Pops on an empty buffer, which expose any state change or wrong sentinel on underflow.
- Pushes running past full, which distinguish the overwrite rule from refusing or corrupting the write.
- Simultaneous push and pop on empty, mid-level and full buffers, each of which catches a different error in the pop-then-push ordering.
- Clears mixed with other strobes.

Seeded random traffic then carries both indices around the wrap many times. Every popped byte and every count is compared with a queue model.

// File: rtl/obuf_pkg.sv
package obuf_pkg;
  localparam int unsigned DEF_DEPTH  = 256;
  localparam int unsigned DEF_DATA_W = 8;

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/obuf_store.sv
module obuf_store #(
  parameter int unsigned DEPTH  = obuf_pkg::DEF_DEPTH,
  parameter int unsigned DATA_W = obuf_pkg::DEF_DATA_W,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // no reset: a slot is read only after it was written
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/obuf_ctrl.sv
module obuf_ctrl #(
  parameter int unsigned DEPTH = obuf_pkg::DEF_DEPTH,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             we_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [IDX_W-1:0] wr_q, rd_q, wr_d, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, empty, do_pop, do_inc, rd_adv;

  assign full  = (cnt_q == FULL_CNT);
  assign empty = (cnt_q == '0);

  // pop first, then push
  assign do_pop = pop_i & ~empty;
  assign do_inc = push_i & (~full | do_pop);
  assign rd_adv = do_pop | (push_i & full);

  always_comb begin
    wr_d  = push_i ? wr_q + 1'b1 : wr_q;
    rd_d  = rd_adv ? rd_q + 1'b1 : rd_q;
    cnt_d = cnt_q + CNT_W'(do_inc) - CNT_W'(do_pop);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  assign we_o     = push_i & ~clear_i;
  assign wr_idx_o = wr_q;
  assign rd_idx_o = rd_q;
  assign empty_o  = empty;
  assign count_o  = cnt_q;
endmodule

// File: rtl/obuf_ring.sv
module obuf_ring #(
  parameter int unsigned DEPTH  = obuf_pkg::DEF_DEPTH,
  parameter int unsigned DATA_W = obuf_pkg::DEF_DATA_W,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              push_valid_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam logic [DATA_W-1:0] SENTINEL = '1;

  logic             we, empty;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [DATA_W-1:0] head;

  obuf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .push_i   (push_valid_i),
    .pop_i    (pop_i),
    .we_o     (we),
    .wr_idx_o (wr_idx),
    .rd_idx_o (rd_idx),
    .empty_o  (empty),
    .count_o  (count_o)
  );

  obuf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) store_i (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (wr_idx),
    .wdata_i (push_data_i),
    .raddr_i (rd_idx),
    .rdata_o (head)
  );

  assign pop_data_o = empty ? SENTINEL : head;
endmodule

// File: rtl/obuf_ring_chk.sv
module obuf_ring_chk #(
  parameter int unsigned DEPTH  = obuf_pkg::DEF_DEPTH,
  parameter int unsigned DATA_W = obuf_pkg::DEF_DATA_W,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              push_valid_i,
  input logic [DATA_W-1:0] push_data_i,
  input logic              pop_i,
  input logic [DATA_W-1:0] pop_data_o,
  input logic [CNT_W-1:0]  count_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  // R1
  clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> count_o == '0);

  // R2
  push_grows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && push_valid_i && !pop_i && count_o != FULL_CNT)
      |=> count_o == $past(count_o) + 1'b1);

  // R2
  first_byte_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && push_valid_i && count_o == '0)
      |=> pop_data_o == $past(push_data_i));

  // R3
  full_push_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && push_valid_i && count_o == FULL_CNT) |=> count_o == FULL_CNT);

  // R4
  pop_shrinks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && pop_i && !push_valid_i && count_o != '0)
      |=> count_o == $past(count_o) - 1'b1);

  // R5
  empty_pop_still_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && pop_i && !push_valid_i && count_o == '0)
      |=> (count_o == '0 && pop_data_o == '1));

  // R6
  both_keep_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && pop_i && push_valid_i && count_o != '0) |=> $stable(count_o));

  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= FULL_CNT);
endmodule

bind obuf_ring obuf_ring_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clear_i      (clear_i),
  .push_valid_i (push_valid_i),
  .push_data_i  (push_data_i),
  .pop_i        (pop_i),
  .pop_data_o   (pop_data_o),
  .count_o      (count_o)
);

// File: tb/obuf_ring_tb_top.sv
module obuf_ring_tb_top;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             clear_i = 1'b0;
  logic             push_valid_i = 1'b0;
  logic [7:0]       push_data_i = '0;
  logic             pop_i = 1'b0;
  logic [7:0]       pop_data_o;
  logic [CNT_W-1:0] count_o;

  int checks = 0;
  int failures = 0;
  logic [7:0] model_q[$];

  always #5 clk = ~clk;

  obuf_ring #(.DEPTH(DEPTH), .DATA_W(8)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .clear_i      (clear_i),
    .push_valid_i (push_valid_i),
    .push_data_i  (push_data_i),
    .pop_i        (pop_i),
    .pop_data_o   (pop_data_o),
    .count_o      (count_o)
  );

  function automatic logic [7:0] exp_head();
    return (model_q.size() > 0) ? model_q[0] : 8'hFF;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, check before the edge, update model, pass the edge
  task automatic step(input string tag, input bit clr, input bit push, input logic [7:0] d, input bit pop);
    @(negedge clk);
    clear_i = clr; push_valid_i = push; push_data_i = d; pop_i = pop;
    #1;
    check(tag, "count", int'(count_o), model_q.size());
    check(tag, "pop_data", int'(pop_data_o), int'(exp_head()));
    if (clr) model_q.delete();
    else begin
      if (pop && model_q.size() > 0) void'(model_q.pop_front());
      if (push) begin
        if (model_q.size() == DEPTH) void'(model_q.pop_front());
        model_q.push_back(d);
      end
    end
    @(posedge clk);
  endtask

  task automatic idle_check(input string tag);
    step(tag, 1'b0, 1'b0, 8'h00, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1", "reset count", int'(count_o), 0);
    check("R1", "reset pop_data", int'(pop_data_o), 8'hFF);
    @(negedge clk);
    rst_ni = 1'b1;

    // R5 underflow has no effect
    step("R5", 0, 0, 8'h00, 1);
    step("R5", 0, 0, 8'h00, 1);
    idle_check("R5");

    // R2 appends, R4 pops oldest
    for (int i = 0; i < 5; i++) step("R2", 0, 1, 8'h10 + 8'(i), 0);
    idle_check("R2");
    step("R4", 0, 0, 8'h00, 1);
    step("R4", 0, 0, 8'h00, 1);
    idle_check("R4");

    // R6 mid-level push and pop
    step("R6", 0, 1, 8'hA1, 1);
    step("R6", 0, 1, 8'hA2, 1);
    idle_check("R6");

    // R1 clear, then R6 on empty
    step("R1", 1, 0, 8'h00, 0);
    idle_check("R1");
    step("R6", 0, 1, 8'h5C, 1);
    idle_check("R6");
    step("R4", 0, 0, 8'h00, 1);

    // R3 overwrite past full
    for (int i = 0; i < DEPTH + 5; i++) step("R3", 0, 1, 8'h40 + 8'(i), 0);
    idle_check("R3");
    // R6 on full
    step("R6", 0, 1, 8'hEE, 1);
    idle_check("R6");
    for (int i = 0; i < DEPTH; i++) step("R3", 0, 0, 8'h00, 1);
    idle_check("R5");

    // R1 clear wins over push and pop
    step("R2", 0, 1, 8'h77, 0);
    step("R1", 1, 1, 8'h88, 1);
    idle_check("R1");

    // R7 random traffic across many wraps
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      step("R7", r < 2, ($urandom_range(0, 99)) < 55, 8'($urandom), ($urandom_range(0, 99)) < 45);
    end
    idle_check("R7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule